// File: doc/BRIEF.md
# Inter-Core Interrupt Hub

This shared block lets any of `N_CORES` cores interrupt any other core. Each core has its own command port: a valid/ready pair, a two-bit opcode and a core-number argument. A core uses it to raise an interrupt on another core, to ask whether a core already has an interrupt waiting, to find out which cores are interrupting it, and to acknowledge one of those senders. The hub drives one level interrupt line per core.

Pending interrupts are kept in a target-by-sender bit matrix. Raises from several senders to one target collect in that target's row, so they show as one asserted line. The target then reads a sender vector and acknowledges each sender in turn. The line drops when the last sender bit clears.

When several cores present commands in the same cycle, a fixed-priority arbiter accepts one command per cycle. The lowest core index wins. The other cores see their ready signal low and keep their command on the port. Read results come back on the issuing core's readback slot one cycle after the command is accepted.

Top module: `xirq_hub`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending bit is cleared. After that edge all `irq_o` bits and all `rb_valid` bits are 0.
- R2: Opcode 0 (raise) from core c with argument t ≠ c sets pending bit (t, c). `irq_o[t]` is 1 from the cycle after acceptance.
- R3: A raise whose argument equals the issuing core's own number is ignored. No `irq_o` bit changes, and a later status read of that core shows no new pending interrupt.
- R4: Opcode 1 (status) with argument t returns a readback word whose bit 0 is 1 exactly when core t has any sender bit set. All other bits of the word are 0.
- R5: Opcode 2 (source) returns the calling core's sender vector. Bit i is 1 when core i has a pending interrupt to the caller. The argument is ignored.
- R6: Raises from several senders to one target merge into a single asserted `irq_o` bit. The source vector then shows one bit per sender.
- R7: Opcode 3 (acknowledge) with argument s clears only pending bit (caller, s). Every other bit of the matrix is left as it was.
- R8: `irq_o[t]` stays 1 as long as any sender bit for target t is set. It falls only in the cycle after an acknowledge that clears the last one.
- R9: Among the cores with `cmd_valid` high, only the lowest-numbered one sees `cmd_ready` high. A core with `cmd_valid` low never sees `cmd_ready` high.
- R10: A command accepted in cycle k with opcode 1 or 2 makes `rb_valid` high for the issuing core only in cycle k+1, with the result in that core's slot. In every other case a core's `rb_valid` is 0 and its `rb_data` slot is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | N_CORES | Per-core command request |
| cmd_op | input | 2*N_CORES | Per-core opcode; core c uses bits [2c+1:2c] |
| cmd_arg | input | IDX_W*N_CORES | Per-core core-number argument; core c uses slot c |
| cmd_ready | output | N_CORES | Per-core command accepted this cycle |
| rb_valid | output | N_CORES | Per-core readback valid |
| rb_data | output | N_CORES*N_CORES | Per-core readback word; core c uses bits [N_CORES*c +: N_CORES] |
| irq_o | output | N_CORES | Per-core interrupt line |

## Verification
The bench targets three risky cases. The first is merging: three senders hit one target, some of them in the same cycle, and the source vector and line are then checked while acknowledges arrive one by one. A design that cleared the whole row on an acknowledge would drop the line early, and one that ignored the sender index would report a wrong vector. The second is a self-targeted raise. A design that accepted it would latch an interrupt no core can ever acknowledge through another core. The third is contention and readback routing: simultaneous requests and random traffic show whether a wrong grant order breaks the one-per-cycle rule, and whether read data goes to the wrong slot or lingers for more than one cycle.

// File: rtl/xirq_pkg.sv
// Shared definitions for the inter-core interrupt hub.
// Assumes a two-bit opcode field on every command port.
package xirq_pkg;
    typedef enum logic [1:0] {
        OP_RAISE  = 2'd0,
        OP_STATUS = 2'd1,
        OP_SOURCE = 2'd2,
        OP_ACK    = 2'd3
    } xirq_op_e;
endpackage

// File: rtl/xirq_arbiter.sv
// Fixed-priority request picker: the lowest index with req high wins.
// Assumes at most one command can be served per cycle. The grant is purely
// combinational; clk/rst_n only time the embedded checks.
module xirq_arbiter #(
    parameter int N_CORES = 4,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] req,
    output logic [N_CORES-1:0] gnt,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic               gnt_any
);
    // Scan upward and keep the first requester found.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int i = 0; i < N_CORES; i++) begin
            if (req[i] && !gnt_any) begin
                gnt[i]  = 1'b1;
                gnt_idx = IDX_W'(i);
                gnt_any = 1'b1;
            end
        end
    end

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));

    for (genvar g = 1; g < N_CORES; g++) begin : g_prio
        assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[g] |-> (req[g-1:0] == '0));
    end
endmodule

// File: rtl/xirq_pend_matrix.sv
// Target-by-sender pending matrix. Row t holds the senders waiting on core t;
// the interrupt line of core t is the OR of its row.
// Assumes set and clear never hit the same bit in one cycle (one command per cycle).
module xirq_pend_matrix #(
    parameter int N_CORES = 4,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_en,
    input  logic [IDX_W-1:0]           set_row,
    input  logic [IDX_W-1:0]           set_col,
    input  logic                       clr_en,
    input  logic [IDX_W-1:0]           clr_row,
    input  logic [IDX_W-1:0]           clr_col,
    output logic [N_CORES*N_CORES-1:0] pend_flat,
    output logic [N_CORES-1:0]         irq
);
    logic [N_CORES-1:0] pend_q [N_CORES];

    // Update pending bits on raise and acknowledge; reset empties the matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_CORES; r++) pend_q[r] <= '0;
        end else begin
            if (set_en) pend_q[set_row][set_col] <= 1'b1;
            if (clr_en) pend_q[clr_row][clr_col] <= 1'b0;
        end
    end

    for (genvar r = 0; r < N_CORES; r++) begin : g_row
        assign pend_flat[r*N_CORES +: N_CORES] = pend_q[r];
        assign irq[r] = |pend_q[r];

        assert_fall_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[r]) |-> $past(clr_en && (clr_row == IDX_W'(r))));
        assert_rise_needs_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[r]) |-> $past(set_en && (set_row == IDX_W'(r))));
    end
endmodule

// File: rtl/xirq_readback.sv
// Per-core readback register: a read result lands in the issuer's slot for
// exactly one cycle; idle slots read as zero.
// Assumes at most one read is accepted per cycle.
module xirq_readback #(
    parameter int N_CORES = 4,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [IDX_W-1:0]           rd_core,
    input  logic [N_CORES-1:0]         rd_word,
    output logic [N_CORES-1:0]         rb_valid,
    output logic [N_CORES*N_CORES-1:0] rb_data
);
    logic [N_CORES-1:0] word_q [N_CORES];
    logic [N_CORES-1:0] valid_q;

    // Load the issuer's slot for one cycle, clear everything else.
    always_ff @(posedge clk) begin
        valid_q <= '0;
        for (int c = 0; c < N_CORES; c++) word_q[c] <= '0;
        if (rst_n && rd_en) begin
            valid_q[rd_core] <= 1'b1;
            word_q[rd_core]  <= rd_word;
        end
    end

    assign rb_valid = valid_q;
    for (genvar c = 0; c < N_CORES; c++) begin : g_slot
        assign rb_data[c*N_CORES +: N_CORES] = word_q[c];
    end

    assert_one_reader_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rb_valid));
    assert_reader_served_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rb_valid[$past(rd_core)]);
endmodule

// File: rtl/xirq_hub.sv
// Inter-core interrupt hub top: arbitrates per-core command ports, decodes the
// winning command into matrix updates or a readback, and drives irq_o.
// Assumes commands are held on the port until cmd_ready is seen.
module xirq_hub
    import xirq_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CORES-1:0]         cmd_valid,
    input  logic [2*N_CORES-1:0]       cmd_op,
    input  logic [IDX_W*N_CORES-1:0]   cmd_arg,
    output logic [N_CORES-1:0]         cmd_ready,
    output logic [N_CORES-1:0]         rb_valid,
    output logic [N_CORES*N_CORES-1:0] rb_data,
    output logic [N_CORES-1:0]         irq_o
);
    localparam logic [IDX_W:0] CORE_LIM = (IDX_W+1)'(N_CORES);

    logic [IDX_W-1:0]           caller;
    logic                       accept;
    xirq_op_e                   op;
    logic [IDX_W-1:0]           arg;
    logic                       arg_ok;
    logic [N_CORES*N_CORES-1:0] pend_flat;
    logic [N_CORES-1:0]         caller_row;
    logic [N_CORES-1:0]         target_row;
    logic                       set_en;
    logic                       clr_en;
    logic                       rd_en;
    logic [N_CORES-1:0]         rd_word;

    xirq_arbiter #(.N_CORES(N_CORES)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cmd_valid),
        .gnt     (cmd_ready),
        .gnt_idx (caller),
        .gnt_any (accept)
    );

    // Select the winning command and classify it.
    always_comb begin
        op         = xirq_op_e'(cmd_op[caller*2 +: 2]);
        arg        = cmd_arg[caller*IDX_W +: IDX_W];
        arg_ok     = {1'b0, arg} < CORE_LIM;
        caller_row = pend_flat[caller*N_CORES +: N_CORES];
        target_row = arg_ok ? pend_flat[arg*N_CORES +: N_CORES] : '0;
        set_en     = accept && (op == OP_RAISE) && arg_ok && (arg != caller);
        clr_en     = accept && (op == OP_ACK) && arg_ok;
        rd_en      = accept && ((op == OP_STATUS) || (op == OP_SOURCE));
        rd_word    = (op == OP_SOURCE) ? caller_row
                                       : {{(N_CORES-1){1'b0}}, |target_row};
    end

    xirq_pend_matrix #(.N_CORES(N_CORES)) u_mat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_en),
        .set_row   (arg),
        .set_col   (caller),
        .clr_en    (clr_en),
        .clr_row   (caller),
        .clr_col   (arg),
        .pend_flat (pend_flat),
        .irq       (irq_o)
    );

    xirq_readback #(.N_CORES(N_CORES)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_core  (caller),
        .rd_word  (rd_word),
        .rb_valid (rb_valid),
        .rb_data  (rb_data)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((irq_o == '0) && (rb_valid == '0)));
    assert_self_raise_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_RAISE) && (arg == caller)) |=> $stable(irq_o));
    assert_raise_sets_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> irq_o[$past(arg)]);
    assert_no_ready_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid == '0) |-> (cmd_ready == '0));
endmodule

// File: tb/xirq_hub_test.sv
module xirq_hub_test;
    localparam int N      = 4;
    localparam int IW     = 2;
    localparam int CLK_NS = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   cmd_valid = '0;
    logic [2*N-1:0] cmd_op = '0;
    logic [IW*N-1:0] cmd_arg = '0;
    logic [N-1:0]   cmd_ready;
    logic [N-1:0]   rb_valid;
    logic [N*N-1:0] rb_data;
    logic [N-1:0]   irq_o;

    xirq_hub #(.N_CORES(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_ready(cmd_ready), .rb_valid(rb_valid),
        .rb_data(rb_data), .irq_o(irq_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    // Stimulus held per core until the model says it was accepted.
    bit        v   [N];
    int        opv [N];
    int        argv[N];
    bit        rst_req = 1'b1;

    // Behavioural reference state.
    bit        pend [N][N];
    bit [N-1:0] exp_rv;
    bit [N-1:0] exp_rd [N];

    function automatic bit [N-1:0] exp_irq();
        bit [N-1:0] r = '0;
        for (int t = 0; t < N; t++)
            for (int s = 0; s < N; s++)
                if (pend[t][s]) r[t] = 1'b1;
        return r;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: compare registered outputs, drive, check ready, update model.
    task automatic cyc();
        int g;
        @(negedge clk);
        chk(cur_req, "irq_o", 32'(irq_o), 32'(exp_irq()));
        chk(cur_req, "rb_valid", 32'(rb_valid), 32'(exp_rv));
        for (int c = 0; c < N; c++)
            chk(cur_req, "rb_data", 32'(rb_data[c*N +: N]), 32'(exp_rd[c]));
        rst_n = !rst_req;
        for (int c = 0; c < N; c++) begin
            cmd_valid[c]        = v[c];
            cmd_op[c*2 +: 2]    = 2'(opv[c]);
            cmd_arg[c*IW +: IW] = IW'(argv[c]);
        end
        g = -1;
        for (int c = N-1; c >= 0; c--) if (v[c]) g = c;
        #1;
        chk("R9", "cmd_ready", 32'(cmd_ready), (g >= 0) ? (32'd1 << g) : 32'd0);
        @(posedge clk);
        #1;
        exp_rv = '0;
        for (int c = 0; c < N; c++) exp_rd[c] = '0;
        if (rst_req) begin
            for (int t = 0; t < N; t++)
                for (int s = 0; s < N; s++) pend[t][s] = 1'b0;
        end else if (g >= 0) begin
            case (opv[g])
                0: if (argv[g] != g) pend[argv[g]][g] = 1'b1;
                1: begin
                    exp_rv[g] = 1'b1;
                    for (int s = 0; s < N; s++)
                        if (pend[argv[g]][s]) exp_rd[g] = 1;
                end
                2: begin
                    exp_rv[g] = 1'b1;
                    for (int s = 0; s < N; s++) exp_rd[g][s] = pend[g][s];
                end
                default: pend[g][argv[g]] = 1'b0;
            endcase
            v[g] = 1'b0;
        end
    endtask

    task automatic post(int c, int o, int a);
        v[c] = 1'b1; opv[c] = o; argv[c] = a;
    endtask

    task automatic drain();
        for (int k = 0; k < 20; k++) begin
            bit busy = 0;
            for (int c = 0; c < N; c++) busy |= v[c];
            if (!busy) break;
            cyc();
        end
        cyc();
    endtask

    task automatic issue(int c, int o, int a);
        post(c, o, a);
        drain();
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) begin v[c] = 0; opv[c] = 0; argv[c] = 0; end
        for (int t = 0; t < N; t++) for (int s = 0; s < N; s++) pend[t][s] = 0;
        exp_rv = '0;
        for (int c = 0; c < N; c++) exp_rd[c] = '0;

        cur_req = "R1";
        rst_req = 1'b1;
        cyc(); cyc(); cyc();
        rst_req = 1'b0;
        cyc(); cyc();

        cur_req = "R2";
        issue(0, 0, 2);
        cur_req = "R5";
        issue(2, 2, 0);
        cur_req = "R4";
        issue(1, 1, 2);
        issue(3, 1, 0);

        cur_req = "R6";
        post(1, 0, 2); post(3, 0, 2);
        drain();
        issue(2, 2, 3);

        cur_req = "R7";
        issue(2, 3, 1);
        cur_req = "R8";
        issue(2, 2, 0);
        issue(2, 3, 0);
        issue(3, 1, 2);
        issue(2, 3, 3);

        cur_req = "R3";
        issue(1, 0, 1);
        issue(0, 1, 1);

        cur_req = "R9";
        post(3, 0, 1); post(2, 0, 1); post(0, 2, 0); post(1, 1, 1);
        drain();

        cur_req = "R10";
        for (int k = 0; k < 600; k++) begin
            for (int c = 0; c < N; c++)
                if (!v[c] && ($urandom % 3 == 0))
                    post(c, int'($urandom % 4), int'($urandom % N));
            cyc();
        end
        drain();

        cur_req = "R1";
        issue(0, 0, 1);
        issue(2, 0, 3);
        rst_req = 1'b1;
        cyc(); cyc();
        rst_req = 1'b0;
        cyc(); cyc();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule